// File: doc/BRIEF.md
# CAN Transmit Buffer Abort Controller

This block keeps the per-buffer control and status flags for three CAN transmit message buffers. Each buffer has four flags: an empty flag, a pending-abort flag, an abort-acknowledge flag and an empty-interrupt enable. The host CPU reaches them through two byte-wide registers. The control register holds the abort requests and the interrupt enables. The status register holds the empty flags and the acknowledge flags.

The host schedules a buffer by writing 1 to that buffer's empty position in the status register. It can then ask for the buffer to be withdrawn by writing 1 to the buffer's abort position. The transmit engine reports which buffer it has on the bus and pulses a completion strobe when the send finishes. The block grants an abort only when the buffer is not on the bus, and a frame that is already on the bus finishes normally. Every event that sets an empty flag also clears that buffer's abort request. A single level interrupt goes high while any buffer is empty and has its enable set.

Top module: `can_txabort_ctl`

## Requirements
- R1: After reset, the control register (reg_sel=0) reads 0x00, the status register (reg_sel=1) reads 0x07 and irq is 0.
- R2: The control register keeps the interrupt enables of buffers 0..2 in bits 2:0, which read back as written. It shows the abort requests of buffers 0..2 in bits 6:4. Bits 7 and 3 always read 0.
- R3: The status register shows the empty flags of buffers 0..2 in bits 2:0 and the acknowledge flags in bits 6:4. Writing 1 to an empty bit that is set clears that empty bit and the buffer's acknowledge bit in the next cycle. Writing 0 changes nothing.
- R4: Writing 1 to an abort bit sets the request only when that buffer's empty flag is 0. A write of 0 never clears a pending request.
- R5: A pending abort on a scheduled buffer that is not being sent is granted at the next clock edge. The grant sets the buffer's empty and acknowledge flags and clears the request.
- R6: While tx_busy is 1 and tx_sel selects a buffer, an abort request for that buffer stays pending and is not granted. If tx_busy falls without a completion, the request is granted at the next edge.
- R7: A tx_done pulse for the selected, scheduled buffer sets its empty flag, clears its acknowledge flag and clears any abort request.
- R8: irq is 1 exactly when some buffer has both its empty flag and its interrupt enable set.
- R9: An abort-request write that lands in the same cycle as the completion of that buffer's send leaves the request cleared and the acknowledge flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| tx_busy | input | 1 | Transmit engine has a buffer on the bus |
| tx_sel | input | 2 | Index of the buffer on the bus |
| tx_done | input | 1 | Single-cycle strobe: the send of tx_sel finished |
| irq | output | 1 | Transmitter-empty interrupt |

## Verification
Two functions can meet in one cycle: a host write that raises an abort request, and the transmit engine's completion strobe for that same buffer. The bench drives the control-register write and tx_done in the same clock cycle while the buffer is on the bus. It then judges the result through both registers. The buffer must read empty with no acknowledge and no request left, which shows that the completion path won.

// File: rtl/can_txabort_ctl.sv
module can_txabort_ctl #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic             tx_busy,
  input  logic [SEL_W-1:0] tx_sel,
  input  logic             tx_done,
  output logic             irq
);
  localparam int NBUF = 3;

  logic [NBUF-1:0] empty_q, ack_q, abort_q, ie_q;
  logic [NBUF-1:0] sending, finish, grant, sched, abort_set;
  logic            wr_ctrl, wr_stat;

  assign wr_ctrl = wr_en && !reg_sel;
  assign wr_stat = wr_en &&  reg_sel;

  always_comb begin
    for (int i = 0; i < NBUF; i++) begin
      sending[i] = tx_busy && (tx_sel == SEL_W'(i));
      grant[i]   = abort_q[i] && !empty_q[i] && !sending[i];
      finish[i]  = grant[i] || (sending[i] && tx_done && !empty_q[i]);
    end
  end

  assign sched     = {NBUF{wr_stat}} & wr_data[NBUF-1:0] & empty_q;
  assign abort_set = {NBUF{wr_ctrl}} & wr_data[NBUF+3:4] & ~empty_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty_q <= '1;
      ack_q   <= '0;
      abort_q <= '0;
      ie_q    <= '0;
    end else begin
      if (wr_ctrl) ie_q <= wr_data[NBUF-1:0];
      empty_q <= (empty_q | finish) & ~sched;
      ack_q   <= (ack_q & ~finish & ~sched) | grant;
      abort_q <= (abort_q | abort_set) & ~finish;
    end
  end

  assign rd_data = reg_sel ? {1'b0, ack_q, 1'b0, empty_q}
                           : {1'b0, abort_q, 1'b0, ie_q};
  assign irq = |(empty_q & ie_q);

  // R4
  abort_only_scheduled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_q & empty_q) == '0);

  // R8
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == '0) |-> !irq);

  for (genvar g = 0; g < NBUF; g++) begin : g_chk
    // R5
    grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_q[g] && !empty_q[g] && !(tx_busy && tx_sel == SEL_W'(g)))
      |=> (empty_q[g] && ack_q[g] && !abort_q[g]));

    // R6
    hold_on_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_busy && tx_sel == SEL_W'(g) && !tx_done && !empty_q[g])
      |=> !empty_q[g]);

    // R7
    done_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_busy && tx_sel == SEL_W'(g) && tx_done && !empty_q[g])
      |=> (empty_q[g] && !ack_q[g] && !abort_q[g]));
  end
endmodule

// File: tb/can_txabort_ctl_bench.sv
`timescale 1ns/1ps
module can_txabort_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       tx_busy = 1'b0;
  logic [1:0] tx_sel = '0;
  logic       tx_done = 1'b0;
  logic       irq;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  can_txabort_ctl u_can_txabort_ctl (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .tx_busy(tx_busy),
    .tx_sel(tx_sel), .tx_done(tx_done), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_reg(input logic sel, input logic [7:0] exp, input string req);
    reg_sel = sel;
    #0.1;
    check(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic chk_irq(input logic exp, input string req);
    #0.1;
    check(irq == exp, req, irq, exp);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk_reg(1'b0, 8'h00, "R1");
    chk_reg(1'b1, 8'h07, "R1");
    chk_irq(1'b0, "R1");
  endtask

  task automatic t_ctrl_layout;
    wr(1'b0, 8'hFF);
    chk_reg(1'b0, 8'h07, "R2");
    chk_irq(1'b1, "R8");
    wr(1'b0, 8'h02);
    chk_reg(1'b0, 8'h02, "R2");
    chk_irq(1'b1, "R8");
    wr(1'b0, 8'h00);
    chk_irq(1'b0, "R8");
  endtask

  task automatic t_schedule;
    wr(1'b1, 8'h01);
    chk_reg(1'b1, 8'h06, "R3");
    wr(1'b1, 8'h00);
    chk_reg(1'b1, 8'h06, "R3");
  endtask

  task automatic t_abort_idle;
    wr(1'b0, 8'h11);
    chk_reg(1'b0, 8'h11, "R4");
    chk_irq(1'b0, "R8");
    tick(1);
    chk_reg(1'b1, 8'h17, "R5");
    chk_reg(1'b0, 8'h01, "R5");
    chk_irq(1'b1, "R8");
  endtask

  task automatic t_abort_busy;
    wr(1'b1, 8'h02);
    chk_reg(1'b1, 8'h15, "R3");
    @(negedge clk);
    tx_busy = 1'b1; tx_sel = 2'd1;
    wr(1'b0, 8'h20);
    tick(3);
    chk_reg(1'b1, 8'h15, "R6");
    chk_reg(1'b0, 8'h20, "R6");
    wr(1'b0, 8'h00);
    chk_reg(1'b0, 8'h20, "R4");
    @(negedge clk);
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0; tx_busy = 1'b0;
    chk_reg(1'b1, 8'h17, "R7");
    chk_reg(1'b0, 8'h00, "R7");
  endtask

  task automatic t_collision;
    wr(1'b1, 8'h04);
    chk_reg(1'b1, 8'h13, "R3");
    @(negedge clk);
    tx_busy = 1'b1; tx_sel = 2'd2;
    @(negedge clk);
    reg_sel = 1'b0; wr_data = 8'h40; wr_en = 1'b1; tx_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tx_done = 1'b0; tx_busy = 1'b0;
    chk_reg(1'b1, 8'h17, "R9");
    chk_reg(1'b0, 8'h00, "R9");
    tick(2);
    chk_reg(1'b1, 8'h17, "R9");
    wr(1'b1, 8'h01);
    chk_reg(1'b1, 8'h06, "R3");
  endtask

  task automatic t_busy_drop;
    @(negedge clk);
    tx_busy = 1'b1; tx_sel = 2'd0;
    wr(1'b0, 8'h10);
    tick(2);
    chk_reg(1'b1, 8'h06, "R6");
    tx_busy = 1'b0;
    @(negedge clk);
    chk_reg(1'b1, 8'h17, "R6");
    chk_reg(1'b0, 8'h00, "R6");
    wr(1'b0, 8'h04);
    chk_irq(1'b1, "R8");
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_ctrl_layout();
    t_schedule();
    t_abort_idle();
    t_abort_busy();
    t_collision();
    t_busy_drop();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule